// File: doc/BRIEF.md
# CAN Message Slot Control and Status Register

This block holds the control and status flags for one message slot of a CAN controller. The host reads and writes it as a single 8-bit register. The CAN protocol engine drives three single-cycle event strobes into it: transmission completed, frame received and stored, and remote frame seen for this slot. In return the block tells the engine whether the slot may be used, whether a transmission is pending, and whether a remote frame may be answered automatically now. It also raises the slot's interrupt request line.

The flags do not all have the same owner. Some are plain host settings. The interrupt flag is set by the engine and cleared only by the host. The remote-request flag is set by the engine, and the host can only clear it. When the host and the engine touch the same flag in the same cycle, the engine's set wins, so no event is lost. The direction of the slot (1 = transmit) comes from a separate configuration register as an input. Global interrupt masking is done outside this block.

Top module: `can_slot_ctl`

## Requirements
- R1: After reset the register reads 0x00 and all engine-facing outputs are 0.
- R2: The register layout, from bit 7 down to bit 0, is: ready, transmit-interrupt enable, receive-interrupt enable, interrupt flag, remote request, transmit request, hold, data updated. A host write stores bits 7, 6, 5, 2, 1 and 0 as written.
- R3: A pulse on soft_rst_i clears the ready bit and leaves every other bit unchanged. If the host writes in the same cycle, the soft reset still wins for the ready bit.
- R4: While ready is 0, all three engine strobes are ignored, and slot_en_o, tx_pend_o and rmt_reply_o are 0.
- R5: A transmit-done strobe sets the interrupt flag only when transmit-interrupt enable is 1. A receive-stored strobe sets it only when receive-interrupt enable is 1.
- R6: Engine events never clear the interrupt flag. A host write sets bit 4 to the value written.
- R7: The host can only clear bit 3. Writing 0 clears it, and writing 1 has no effect.
- R8: A remote-frame strobe sets bit 3 in either direction. A transmit-done strobe on a slot with dir_i = 1 clears bits 3 and 2.
- R9: rmt_reply_o is 1 exactly when ready, dir_i, bit 3 and data updated are all 1 and hold is 0.
- R10: If an engine set and a host clear hit bit 4 or bit 3 in the same cycle, the bit ends up set.
- R11: tx_pend_o is 1 exactly when ready, dir_i and bit 2 are all 1. irq_o follows bit 4.
- R12: With RX_ONLY = 1, transmit-interrupt enable has no effect: a transmit-done strobe never sets the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst_i | input | 1 | Controller soft reset; clears ready |
| dir_i | input | 1 | Slot direction, 1 = transmit |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Register read value |
| tx_done_i | input | 1 | Engine: transmission completed |
| rx_store_i | input | 1 | Engine: frame received and stored |
| rmt_seen_i | input | 1 | Engine: remote frame for this slot seen |
| slot_en_o | output | 1 | Slot may be used by the engine |
| tx_pend_o | output | 1 | Transmission requested |
| rmt_reply_o | output | 1 | Remote frame may be answered now |
| irq_o | output | 1 | Interrupt request |

## Verification
Every flag is a register that the read port shows directly. A wrong internal state therefore appears on rd_data_o in the cycle after the event or write that caused it. The engine-facing outputs are combinational functions of those flags and dir_i, so a wrong reply or pending decision appears in that same cycle. The race between engine sets and host clears can only be seen on the one edge where both occur, so the bench drives both in the same cycle and reads the register right after that edge.

// File: rtl/can_slot_pkg.sv
// Shared constants for the CAN message slot register.
// Assumes one 8-bit register. The bit positions are part of the host-visible contract.
package can_slot_pkg;
    localparam int REG_W    = 8;
    localparam int B_READY  = 7;
    localparam int B_TXIE   = 6;
    localparam int B_RXIE   = 5;
    localparam int B_IRQ    = 4;
    localparam int B_XRQ    = 3;
    localparam int B_TXRQ   = 2;
    localparam int B_HOLD   = 1;
    localparam int B_DUPD   = 0;

    // Register image, MSB first.
    typedef struct packed {
        logic ready;
        logic txie;
        logic rxie;
        logic irq;
        logic xrq;
        logic txrq;
        logic hold;
        logic dupd;
    } slot_reg_t;
endpackage

// File: rtl/slot_cfg_reg.sv
// Holds the flags that belong to the host: ready, the two interrupt enables, hold and data updated.
// Assumes the soft reset is a single-cycle strobe from the controller. It only affects ready.
module slot_cfg_reg
    import can_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic             ready_o,
    output logic             txie_o,
    output logic             rxie_o,
    output logic             hold_o,
    output logic             dupd_o
);
    // Ready bit: host writes it; either reset clears it, and soft reset beats a write.
    always_ff @(posedge clk) begin
        if (!rst_n)          ready_o <= 1'b0;
        else if (soft_rst_i) ready_o <= 1'b0;
        else if (wr_en_i)    ready_o <= wr_data_i[B_READY];
    end

    // Plain host settings, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txie_o <= 1'b0;
            rxie_o <= 1'b0;
            hold_o <= 1'b0;
            dupd_o <= 1'b0;
        end else if (wr_en_i) begin
            txie_o <= wr_data_i[B_TXIE];
            rxie_o <= wr_data_i[B_RXIE];
            hold_o <= wr_data_i[B_HOLD];
            dupd_o <= wr_data_i[B_DUPD];
        end
    end
endmodule

// File: rtl/slot_event_reg.sv
// Holds the flags shared by host and engine: interrupt flag, remote request and transmit request.
// Assumes the engine strobes last one cycle. When ready is low, all strobes are masked.
module slot_event_reg
    import can_slot_pkg::*;
#(
    parameter bit RX_ONLY = 1'b0
)(
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic dir_i,
    input  logic txie_i,
    input  logic rxie_i,
    input  logic wr_en_i,
    input  logic wr_irq_i,
    input  logic wr_xrq_i,
    input  logic wr_txrq_i,
    input  logic tx_done_i,
    input  logic rx_store_i,
    input  logic rmt_seen_i,
    output logic irq_o,
    output logic xrq_o,
    output logic txrq_o
);
    logic tx_irq_en;
    logic tx_ev, rx_ev, rmt_ev, irq_set, tx_clr;

    // A receive-only slot never lets the transmit enable take effect.
    generate
        if (RX_ONLY) begin : g_rx_only
            assign tx_irq_en = 1'b0;
        end else begin : g_txrx
            assign tx_irq_en = txie_i;
        end
    endgenerate

    // Qualify engine strobes with ready and derive set/clear terms.
    always_comb begin
        tx_ev   = tx_done_i  & ready_i;
        rx_ev   = rx_store_i & ready_i;
        rmt_ev  = rmt_seen_i & ready_i;
        irq_set = (tx_ev & tx_irq_en) | (rx_ev & rxie_i);
        tx_clr  = tx_ev & dir_i;
    end

    // Interrupt flag: an engine set beats the host write; no hardware clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_o <= 1'b0;
        else if (irq_set) irq_o <= 1'b1;
        else if (wr_en_i) irq_o <= wr_irq_i;
    end

    // Remote request: engine sets it; a finished transmit clears it; the host may only clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    xrq_o <= 1'b0;
        else if (rmt_ev)               xrq_o <= 1'b1;
        else if (tx_clr)               xrq_o <= 1'b0;
        else if (wr_en_i && !wr_xrq_i) xrq_o <= 1'b0;
    end

    // Transmit request: host writes it; a finished transmit on a transmit slot clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       txrq_o <= 1'b0;
        else if (wr_en_i) txrq_o <= wr_txrq_i;
        else if (tx_clr)  txrq_o <= 1'b0;
    end
endmodule

// File: rtl/slot_query.sv
// Combinational answers to the engine, built from the stored flags and the direction.
// Assumes the flags are registered. Every answer is forced low while ready is 0.
module slot_query (
    input  logic ready_i,
    input  logic dir_i,
    input  logic xrq_i,
    input  logic txrq_i,
    input  logic hold_i,
    input  logic dupd_i,
    output logic slot_en_o,
    output logic tx_pend_o,
    output logic rmt_reply_o
);
    // Gate every engine-facing answer with ready.
    always_comb begin
        slot_en_o   = ready_i;
        tx_pend_o   = ready_i & dir_i & txrq_i;
        rmt_reply_o = ready_i & dir_i & xrq_i & dupd_i & ~hold_i;
    end
endmodule

// File: rtl/can_slot_ctl.sv
// Control and status register for one CAN message slot. It ties together host-owned
// flags, shared event flags and the engine query logic.
// Assumes a single-register host port with no address and single-cycle engine strobes.
module can_slot_ctl
    import can_slot_pkg::*;
#(
    parameter bit RX_ONLY = 1'b0
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             dir_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             tx_done_i,
    input  logic             rx_store_i,
    input  logic             rmt_seen_i,
    output logic             slot_en_o,
    output logic             tx_pend_o,
    output logic             rmt_reply_o,
    output logic             irq_o
);
    logic ready, txie, rxie, hold, dupd, irq, xrq, txrq;
    slot_reg_t img;

    slot_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .ready_o    (ready),
        .txie_o     (txie),
        .rxie_o     (rxie),
        .hold_o     (hold),
        .dupd_o     (dupd)
    );

    slot_event_reg #(.RX_ONLY(RX_ONLY)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready),
        .dir_i      (dir_i),
        .txie_i     (txie),
        .rxie_i     (rxie),
        .wr_en_i    (wr_en_i),
        .wr_irq_i   (wr_data_i[B_IRQ]),
        .wr_xrq_i   (wr_data_i[B_XRQ]),
        .wr_txrq_i  (wr_data_i[B_TXRQ]),
        .tx_done_i  (tx_done_i),
        .rx_store_i (rx_store_i),
        .rmt_seen_i (rmt_seen_i),
        .irq_o      (irq),
        .xrq_o      (xrq),
        .txrq_o     (txrq)
    );

    slot_query u_qry (
        .ready_i     (ready),
        .dir_i       (dir_i),
        .xrq_i       (xrq),
        .txrq_i      (txrq),
        .hold_i      (hold),
        .dupd_i      (dupd),
        .slot_en_o   (slot_en_o),
        .tx_pend_o   (tx_pend_o),
        .rmt_reply_o (rmt_reply_o)
    );

    // Assemble the read image in register order.
    always_comb begin
        img.ready = ready;
        img.txie  = txie;
        img.rxie  = rxie;
        img.irq   = irq;
        img.xrq   = xrq;
        img.txrq  = txrq;
        img.hold  = hold;
        img.dupd  = dupd;
        rd_data_o = img;
        irq_o     = irq;
    end
endmodule

// File: rtl/can_slot_ctl_chk.sv
// Port-level properties for can_slot_ctl, attached by bind.
module can_slot_ctl_chk #(
    parameter bit RX_ONLY = 1'b0
)(
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst_i,
    input logic       dir_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       tx_done_i,
    input logic       rx_store_i,
    input logic       rmt_seen_i,
    input logic       slot_en_o,
    input logic       tx_pend_o,
    input logic       rmt_reply_o,
    input logic       irq_o
);
    // R3
    soft_rst_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst_i) |-> !rd_data_o[7]);

    // R4
    not_ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[7] |-> !(slot_en_o || tx_pend_o || rmt_reply_o));

    // R5
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((wr_en_i && wr_data_i[4]) ||
            (rd_data_o[7] && rx_store_i && rd_data_o[5]) ||
            (rd_data_o[7] && tx_done_i && rd_data_o[6] && !RX_ONLY)));

    // R6
    irq_fall_host_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_en_i && !wr_data_i[4]));

    // R8
    xrq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data_o[3]) |-> $past(rmt_seen_i && rd_data_o[7]));

    // R9
    reply_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rmt_reply_o |-> (dir_i && rd_data_o[3] && rd_data_o[0] && !rd_data_o[1]));

    // R11
    irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == rd_data_o[4]);
endmodule

bind can_slot_ctl can_slot_ctl_chk #(.RX_ONLY(RX_ONLY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst_i  (soft_rst_i),
    .dir_i       (dir_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .tx_done_i   (tx_done_i),
    .rx_store_i  (rx_store_i),
    .rmt_seen_i  (rmt_seen_i),
    .slot_en_o   (slot_en_o),
    .tx_pend_o   (tx_pend_o),
    .rmt_reply_o (rmt_reply_o),
    .irq_o       (irq_o)
);

// File: tb/tb_can_slot_ctl.sv
// Directed bench for can_slot_ctl. A second instance with RX_ONLY = 1 shares the same stimulus.
module tb_can_slot_ctl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0, dir = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_done = 1'b0, rx_store = 1'b0, rmt_seen = 1'b0;
    logic [7:0] rd, rd_rx;
    logic       slot_en, tx_pend, rmt_reply, irq;
    logic       slot_en_x, tx_pend_x, rmt_reply_x, irq_x;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_slot_ctl #(.RX_ONLY(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .dir_i(dir),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd),
        .tx_done_i(tx_done), .rx_store_i(rx_store), .rmt_seen_i(rmt_seen),
        .slot_en_o(slot_en), .tx_pend_o(tx_pend), .rmt_reply_o(rmt_reply), .irq_o(irq));

    can_slot_ctl #(.RX_ONLY(1'b1)) dut_rx (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .dir_i(dir),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_rx),
        .tx_done_i(tx_done), .rx_store_i(rx_store), .rmt_seen_i(rmt_seen),
        .slot_en_o(slot_en_x), .tx_pend_o(tx_pend_x), .rmt_reply_o(rmt_reply_x), .irq_o(irq_x));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus starting at a falling edge, then sample 1 ns after the next rising edge.
    task automatic cyc(input logic we, input logic [7:0] d, input logic td, input logic rs,
                       input logic rm, input logic sr);
        @(negedge clk);
        wr_en = we; wr_data = d; tx_done = td; rx_store = rs; rmt_seen = rm; soft_rst = sr;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tx_done = 1'b0; rx_store = 1'b0; rmt_seen = 1'b0; soft_rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 reg", rd, 8'h00);
        chk("R1 outs", {4'h0, slot_en, tx_pend, rmt_reply, irq}, 8'h00);
    endtask

    task automatic t_write_layout;
        dir = 1'b1;
        wr(8'hE7);
        chk("R2/R7 readback", rd, 8'hE7 & 8'hF7);
        chk("R11 tx_pend", {7'h0, tx_pend}, 8'h01);
        chk("R4 slot_en", {7'h0, slot_en}, 8'h01);
    endtask

    task automatic t_soft_reset;
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 soft reset", rd, 8'h67);
        chk("R4 outputs off", {5'h0, slot_en, tx_pend, rmt_reply}, 8'h00);
        cyc(1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 beats write", rd, 8'h00);
    endtask

    task automatic t_not_ready;
        dir = 1'b1;
        wr(8'h65);
        cyc(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4 strobes ignored", rd, 8'h65);
        chk("R4 queries low", {5'h0, slot_en, tx_pend, rmt_reply}, 8'h00);
    endtask

    task automatic t_irq_enables;
        dir = 1'b0;
        wr(8'hA0);
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5 rx sets irq", rd, 8'hB0);
        chk("R11 irq pin", {7'h0, irq}, 8'h01);
        wr(8'hA0);
        chk("R6 host clears", rd, 8'hA0);
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 tx no enable", rd, 8'hA0);
        wr(8'hC0);
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 tx sets irq", rd, 8'hD0);
        chk("R12 rx-only tx ignored", rd_rx, 8'hC0);
        cyc(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R6 events keep irq", rd, 8'hD0);
        wr(8'hC0);
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5 rx no enable", rd, 8'hC0);
        wr(8'h90);
        chk("R6 host sets irq", rd, 8'h90);
    endtask

    task automatic t_remote;
        dir = 1'b0;
        wr(8'h80);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 rx-dir records", rd, 8'h88);
        chk("R9 no reply rx dir", {7'h0, rmt_reply}, 8'h00);
        wr(8'h88);
        chk("R7 write1 no effect", rd, 8'h88);
        wr(8'h80);
        chk("R7 write0 clears", rd, 8'h80);
        dir = 1'b1;
        wr(8'h84);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 tx-dir records", rd, 8'h8C);
        chk("R9 no data no reply", {7'h0, rmt_reply}, 8'h00);
        wr(8'h8D);
        chk("R9 reply allowed", {7'h0, rmt_reply}, 8'h01);
        wr(8'h8F);
        chk("R9 hold blocks", {7'h0, rmt_reply}, 8'h00);
        wr(8'h8D);
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 tx done clears", rd, 8'h81);
        chk("R11 tx_pend off", {6'h0, tx_pend, rmt_reply}, 8'h00);
    endtask

    task automatic t_race;
        dir = 1'b0;
        wr(8'hA0);
        cyc(1'b1, 8'hA0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 irq set wins", rd, 8'hB0);
        wr(8'h80);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 xrq set wins", rd, 8'h88);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_write_layout();
        t_soft_reset();
        t_not_ready();
        t_irq_enables();
        t_remote();
        t_race();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule